// File: doc/BRIEF.md
# Real-Time Clock Time-of-Day Counter

This block keeps the time of day as seconds, minutes and hours. A prescaler divides the fast oscillator clock down to a 256 Hz tick, and a second divider turns that into a 1 Hz tick. The 1 Hz tick drives a chain of counters that wrap over and pass a carry to the next field. Software chooses binary or BCD encoding, and 12-hour or 24-hour format. It starts and stops the clock with a run bit, and a read-only status bit shows whether counting has actually started or stopped.

The time can be loaded only while the status bit reads 0. Loading the time while the clock runs has no effect. Each time 1 is written to the run bit, both dividers are cleared, so a fresh 256 Hz period starts at that moment. The block has three event flags, for the second tick, the minute rollover and the hour advance. Each flag is cleared by writing 1 to it and has its own enable. The interrupt line is high while any enabled flag is set.

Reset stops the clock and clears the flags and the enables. It leaves the time counters at whatever value they hold, so software must load them.

Top module: `rtc_time_core`

## Requirements
- R1: After reset, the control register (address 0) reads 0, so run, status and both mode bits are 0. The flag/enable register (address 3) reads 0, and `irq_o` is 0.
- R2: Control bit 3 (status, read-only) copies control bit 0 (run) at the next 256 Hz tick. After a write of run=1 from idle, status reads 0 for the first OSC_DIV-1 cycles and reads 1 starting OSC_DIV cycles after the write edge.
- R3: A write of 1 to run clears both dividers. Starting from idle, the first seconds increment lands (SEC_DIV+1)*OSC_DIV cycles after the write edge, and each later one comes SEC_DIV*OSC_DIV cycles after the one before.
- R4: A write to address 1 (seconds in bits [6:0], minutes in bits [14:8]) or to address 2 (hours in bits [5:0], PM in bit 6) loads the counters only while status is 0. The same write has no effect while status is 1.
- R5: In binary mode (control bit 1 = 0), seconds and minutes count from 0 to 59. From 59 they return to 0 and carry into the next field.
- R6: In BCD mode (control bit 1 = 1), each field holds the tens digit in its upper bits and the units digit in bits [3:0]. A units value of 9 becomes 0 and increments the tens digit, so 0x09 becomes 0x10. Seconds and minutes wrap from 0x59 to 0x00.
- R7: In 24-hour mode (control bit 2 = 0), hours count from 0 to 23 and then wrap to 0 (0x23 to 0x00 in BCD).
- R8: In 12-hour mode (control bit 2 = 1), hours go 12, 1, 2, …, 11. The step from 11 to 12 inverts the PM bit. In 24-hour mode the PM bit holds its value.
- R9: The flags sit in address 3 bits [2:0]. Bit 0 is set on every seconds increment, bit 1 on every seconds wrap, and bit 2 on every minutes wrap. Writing 1 to a flag bit clears it, and a set in the same cycle takes priority over the clear.
- R10: A write to address 3 also stores bits [10:8] as the flag enables. `irq_o` is 1 exactly when some flag and its enable are both 1.
- R11: While status is 0, the time counters hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Register write address |
| wr_data_i | input | DW | Register write data |
| rd_addr_i | input | AW | Register read address |
| rd_data_o | output | DW | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench checks the exact cycle at which status rises and at which the first second lands after a start. A design that left the dividers running at start, or that skipped the synchronising tick, would be off by a few cycles there. It tries a time write during the gap after the start and before the first second, where a design that ignored the status gate would overwrite the seconds. Scoreboarded runs go through 59→00 wraps, the BCD units-to-tens step, the 23→0 day wrap and the 11→12 and 12→1 steps with their PM handling. A wrong digit carry or a PM bit that moves in 24-hour mode would show up as a mismatched time. The flag sequence covers a partial write-1-to-clear and a flag that is set but masked, where a design that cleared every flag or ignored the enables would fail.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned SEC_W = 7;
  localparam int unsigned HR_W  = 6;
  localparam int unsigned N_EVT = 3;

  // one step of a binary or packed-BCD count
  function automatic logic [SEC_W-1:0] step(input logic [SEC_W-1:0] v, input logic bcd);
    logic [SEC_W-1:0] r;
    if (bcd && v[3:0] == 4'd9) begin
      r = v;
      r[3:0] = 4'd0;
      r[SEC_W-1:4] = v[SEC_W-1:4] + 1'b1;
    end else begin
      r = v + 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned OSC_DIV = 128,
  parameter int unsigned SEC_DIV = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic start_i,
  output logic status_o,
  output logic tick_1hz_o
);
  localparam int unsigned DIV_W = $clog2(OSC_DIV);
  localparam int unsigned SEC_DW = $clog2(SEC_DIV);

  logic [DIV_W-1:0]  div_q;
  logic [SEC_DW-1:0] sdiv_q;
  logic              status_q;
  logic              tick_256;

  assign tick_256   = (div_q == DIV_W'(OSC_DIV - 1));
  assign tick_1hz_o = tick_256 && status_q && (sdiv_q == SEC_DW'(SEC_DIV - 1));
  assign status_o   = status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q    <= '0;
      sdiv_q   <= '0;
      status_q <= 1'b0;
    end else begin
      if (tick_256) status_q <= run_i;
      if (start_i) begin
        div_q  <= '0;
        sdiv_q <= '0;
      end else begin
        div_q <= tick_256 ? '0 : div_q + 1'b1;
        if (tick_256 && status_q)
          sdiv_q <= (sdiv_q == SEC_DW'(SEC_DIV - 1)) ? '0 : sdiv_q + 1'b1;
      end
    end
  end

  assert_status_sync_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(status_q) |-> $past(tick_256));
endmodule

// File: rtl/rtc_base60.sv
module rtc_base60
  import rtc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bcd_i,
  input  logic             inc_i,
  input  logic             ld_i,
  input  logic [SEC_W-1:0] ld_val_i,
  output logic [SEC_W-1:0] val_o,
  output logic             carry_o
);
  logic [SEC_W-1:0] val_q;
  logic             at_max;

  assign at_max  = bcd_i ? (val_q == 7'h59) : (val_q == 7'd59);
  assign carry_o = inc_i && at_max;
  assign val_o   = val_q;

  // time value is not reset by design
  always_ff @(posedge clk_i) begin
    if (ld_i)       val_q <= ld_val_i;
    else if (inc_i) val_q <= at_max ? '0 : step(val_q, bcd_i);
  end

  assert_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i && at_max) |=> (val_q == '0));
  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(val_q) |-> $past(inc_i || ld_i));
endmodule

// File: rtl/rtc_hours.sv
module rtc_hours
  import rtc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bcd_i,
  input  logic            h12_i,
  input  logic            inc_i,
  input  logic            ld_i,
  input  logic [HR_W-1:0] ld_hr_i,
  input  logic            ld_pm_i,
  output logic [HR_W-1:0] hr_o,
  output logic            pm_o
);
  logic [HR_W-1:0] hr_q, hr_d, c_11, c_12, c_23;
  logic            pm_q, pm_d;
  logic [SEC_W-1:0] bumped;

  assign c_11 = bcd_i ? 6'h11 : 6'd11;
  assign c_12 = bcd_i ? 6'h12 : 6'd12;
  assign c_23 = bcd_i ? 6'h23 : 6'd23;
  assign bumped = step({1'b0, hr_q}, bcd_i);

  always_comb begin
    hr_d = bumped[HR_W-1:0];
    pm_d = pm_q;
    if (h12_i) begin
      if (hr_q == c_12) hr_d = 6'd1;
      else if (hr_q == c_11) pm_d = ~pm_q;
    end else if (hr_q == c_23) begin
      hr_d = '0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (ld_i) begin
      hr_q <= ld_hr_i;
      pm_q <= ld_pm_i;
    end else if (inc_i) begin
      hr_q <= hr_d;
      pm_q <= pm_d;
    end
  end

  assign hr_o = hr_q;
  assign pm_o = pm_q;

  assert_day_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i && !h12_i && hr_q == c_23) |=> (hr_q == '0));
  assert_pm_toggle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i && h12_i && hr_q == c_11) |=> (pm_q != $past(pm_q)));
  assert_pm_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!h12_i && !ld_i) |=> $stable(pm_q));
endmodule

// File: rtl/rtc_irq.sv
module rtc_irq #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         en_we_i,
  input  logic [N-1:0] en_d_i,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] en_o,
  output logic         irq_o
);
  logic [N-1:0] flags_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      en_q    <= '0;
    end else begin
      flags_q <= (flags_q & ~clr_i) | set_i;
      if (en_we_i) en_q <= en_d_i;
    end
  end

  assign flags_o = flags_q;
  assign en_o    = en_q;
  assign irq_o   = |(flags_q & en_q);

  assert_w1c_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(clr_i & ~set_i) |=> ((flags_q & $past(clr_i & ~set_i)) == '0));
  assert_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |set_i |=> ((flags_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
#(
  parameter int unsigned OSC_DIV = 128,
  parameter int unsigned SEC_DIV = 256,
  parameter int unsigned AW      = 2,
  parameter int unsigned DW      = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          irq_o
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_MS   = AW'(1);
  localparam logic [AW-1:0] A_HR   = AW'(2);
  localparam logic [AW-1:0] A_IRQ  = AW'(3);

  logic run_q, bcd_q, h12_q, status, tick_1hz;
  logic wr_ctrl, wr_ms, wr_hr, wr_irq, start;
  logic [SEC_W-1:0] sec, min;
  logic [HR_W-1:0]  hr;
  logic pm, sec_carry, min_carry;
  logic [N_EVT-1:0] flags, en;
  logic unused_wr;

  assign wr_ctrl = wr_en_i && (wr_addr_i == A_CTRL);
  assign wr_ms   = wr_en_i && (wr_addr_i == A_MS);
  assign wr_hr   = wr_en_i && (wr_addr_i == A_HR);
  assign wr_irq  = wr_en_i && (wr_addr_i == A_IRQ);
  assign start   = wr_ctrl && wr_data_i[0];
  assign unused_wr = ^{wr_data_i[DW-1:15], wr_data_i[7]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      bcd_q <= 1'b0;
      h12_q <= 1'b0;
    end else if (wr_ctrl) begin
      run_q <= wr_data_i[0];
      bcd_q <= wr_data_i[1];
      h12_q <= wr_data_i[2];
    end
  end

  rtc_prescaler #(.OSC_DIV(OSC_DIV), .SEC_DIV(SEC_DIV)) u_presc (
    .clk_i, .rst_ni, .run_i(run_q), .start_i(start),
    .status_o(status), .tick_1hz_o(tick_1hz)
  );

  rtc_base60 u_sec (
    .clk_i, .rst_ni, .bcd_i(bcd_q), .inc_i(tick_1hz),
    .ld_i(wr_ms && !status), .ld_val_i(wr_data_i[6:0]),
    .val_o(sec), .carry_o(sec_carry)
  );

  rtc_base60 u_min (
    .clk_i, .rst_ni, .bcd_i(bcd_q), .inc_i(sec_carry),
    .ld_i(wr_ms && !status), .ld_val_i(wr_data_i[14:8]),
    .val_o(min), .carry_o(min_carry)
  );

  rtc_hours u_hr (
    .clk_i, .rst_ni, .bcd_i(bcd_q), .h12_i(h12_q), .inc_i(min_carry),
    .ld_i(wr_hr && !status), .ld_hr_i(wr_data_i[5:0]), .ld_pm_i(wr_data_i[6]),
    .hr_o(hr), .pm_o(pm)
  );

  rtc_irq #(.N(N_EVT)) u_irq (
    .clk_i, .rst_ni,
    .set_i({min_carry, sec_carry, tick_1hz}),
    .clr_i(wr_irq ? wr_data_i[2:0] : 3'b000),
    .en_we_i(wr_irq), .en_d_i(wr_data_i[10:8]),
    .flags_o(flags), .en_o(en), .irq_o(irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      A_CTRL: rd_data_o[3:0] = {status, h12_q, bcd_q, run_q};
      A_MS: begin
        rd_data_o[6:0]  = sec;
        rd_data_o[14:8] = min;
      end
      A_HR:  rd_data_o[6:0] = {pm, hr};
      default: begin
        rd_data_o[2:0]  = flags;
        rd_data_o[10:8] = en;
      end
    endcase
  end

  assert_ld_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ms && status && !tick_1hz) |=> $stable(sec));
endmodule

// File: tb/rtc_time_core_tb_top.sv
`timescale 1ns/1ps
module rtc_time_core_tb_top;
  localparam int OSC_DIV = 2;
  localparam int SEC_DIV = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [20:0] exp_q[$];
  bit mon_en = 1'b0;
  string cur_req = "";

  always #2.5 clk = ~clk;

  rtc_time_core #(.OSC_DIV(OSC_DIV), .SEC_DIV(SEC_DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  function automatic int dec(input bit bcd, input logic [6:0] v);
    return bcd ? int'(v[6:4]) * 10 + int'(v[3:0]) : int'(v);
  endfunction

  function automatic logic [6:0] enc(input bit bcd, input int x);
    return bcd ? 7'((x / 10) * 16 + (x % 10)) : 7'(x);
  endfunction

  function automatic logic [20:0] tm(input bit pm, input logic [5:0] h, input logic [6:0] m, input logic [6:0] s);
    return {pm, h, m, s};
  endfunction

  function automatic logic [20:0] model_next(input bit bcd, input bit h12, input logic [20:0] t);
    int s = dec(bcd, t[6:0]);
    int m = dec(bcd, t[13:7]);
    int h = dec(bcd, {1'b0, t[19:14]});
    bit pm = t[20];
    logic [6:0] he;
    s++;
    if (s == 60) begin
      s = 0; m++;
      if (m == 60) begin
        m = 0;
        if (h12) begin
          if (h == 11) begin h = 12; pm = ~pm; end
          else if (h == 12) h = 1;
          else h++;
        end else h = (h + 1) % 24;
      end
    end
    he = enc(bcd, h);
    return {pm, he[5:0], enc(bcd, m), enc(bcd, s)};
  endfunction

  // monitor: pops expected time on every observed change
  initial begin
    logic [20:0] last, now;
    logic [15:0] ms, hh;
    bit have = 1'b0;
    forever begin
      @(negedge clk);
      if (mon_en) begin
        rd_addr = 2'd1; #0.5; ms = rd_data;
        rd_addr = 2'd2; #0.5; hh = rd_data;
        now = {hh[6], hh[5:0], ms[14:8], ms[6:0]};
        if (!have) begin
          last = now; have = 1'b1;
        end else if (now !== last) begin
          if (exp_q.size() == 0) check({cur_req, " unexpected"}, 32'(now), 32'(last));
          else check(cur_req, 32'(now), 32'(exp_q.pop_front()));
          last = now;
        end
      end else have = 1'b0;
    end
  end

  task automatic stop_clock(input bit bcd, input bit h12);
    logic [15:0] d;
    wr(2'd0, {13'b0, h12, bcd, 1'b0});
    for (int i = 0; i < 50; i++) begin
      rd(2'd0, d);
      if (d[3] == 1'b0) break;
      @(negedge clk);
    end
  endtask

  task automatic run_case(input string req, input bit bcd, input bit h12, input logic [20:0] t0, input int n);
    logic [15:0] d;
    logic [20:0] e;
    cur_req = req;
    wr(2'd0, {13'b0, h12, bcd, 1'b0});
    wr(2'd1, {1'b0, t0[13:7], 1'b0, t0[6:0]});
    wr(2'd2, {9'b0, t0[20], t0[19:14]});
    rd(2'd1, d);
    check({req, " R4 idle load"}, 32'(d), 32'({1'b0, t0[13:7], 1'b0, t0[6:0]}));
    e = t0;
    for (int i = 0; i < n; i++) begin
      e = model_next(bcd, h12, e);
      exp_q.push_back(e);
    end
    mon_en = 1'b1;
    @(negedge clk); @(negedge clk);
    wr(2'd0, {13'b0, h12, bcd, 1'b1});
    for (int i = 0; i < 4000 && exp_q.size() != 0; i++) @(posedge clk);
    check({req, " drained"}, 32'(exp_q.size()), 32'd0);
    exp_q.delete();
    mon_en = 1'b0;
    stop_clock(bcd, h12);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d, d2;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, d); check("R1 ctrl", 32'(d), 32'h0);
    rd(2'd3, d); check("R1 flags", 32'(d), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);

    // R2/R3/R4 exact start timing, binary 24h
    wr(2'd1, 16'h000a);
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h0001);                      // after edge E0
    rd(2'd0, d); check("R2 run set, status low", 32'(d), 32'h1);
    @(negedge clk);
    rd(2'd0, d); check("R2 status at E0+1", 32'(d[3]), 32'h0);
    @(negedge clk);
    rd(2'd0, d); check("R2 status at E0+2", 32'(d[3]), 32'h1);
    wr(2'd1, 16'h0000);                      // lands at E0+4, status=1
    rd(2'd1, d); check("R4 write while running ignored", 32'(d), 32'h000a);
    repeat (5) @(negedge clk);
    rd(2'd1, d); check("R3 no tick at E0+9", 32'(d), 32'h000a);
    @(negedge clk);
    rd(2'd1, d); check("R3 first tick at E0+10", 32'(d), 32'h000b);
    stop_clock(1'b0, 1'b0);
    rd(2'd3, d); check("R9 seconds flag only", 32'(d), 32'h0001);
    // R11 hold while stopped
    rd(2'd1, d);
    repeat (40) @(negedge clk);
    rd(2'd1, d2); check("R11 hold while idle", 32'(d2), 32'(d));

    wr(2'd3, 16'h0707);                      // clear all, enable all
    rd(2'd3, d); check("R9 clear all", 32'(d), 32'h0700);
    check("R10 irq low with flags clear", 32'(irq), 32'h0);

    run_case("R5 R7 R8 bin24", 1'b0, 1'b0, tm(1'b1, 6'd23, 7'd59, 7'd57), 5);

    rd(2'd3, d); check("R9 all flags set", 32'(d), 32'h0707);
    check("R10 irq enabled", 32'(irq), 32'h1);
    wr(2'd3, 16'h0001);
    rd(2'd3, d); check("R9 partial clear", 32'(d), 32'h0006);
    check("R10 irq masked", 32'(irq), 32'h0);
    wr(2'd3, 16'h0400);
    rd(2'd3, d); check("R10 enable hour only", 32'(d), 32'h0406);
    check("R10 irq from hour flag", 32'(irq), 32'h1);
    wr(2'd3, 16'h0006);
    rd(2'd3, d); check("R9 clear rest", 32'(d), 32'h0000);
    check("R10 irq cleared", 32'(irq), 32'h0);

    run_case("R6 bcd24 digit carry", 1'b1, 1'b0, tm(1'b0, 6'h09, 7'h59, 7'h58), 13);
    run_case("R7 bcd24 day wrap", 1'b1, 1'b0, tm(1'b0, 6'h23, 7'h59, 7'h59), 2);
    run_case("R8 bin12 11 to 12", 1'b0, 1'b1, tm(1'b0, 6'd11, 7'd59, 7'd58), 4);
    run_case("R8 bin12 12 to 1", 1'b0, 1'b1, tm(1'b1, 6'd12, 7'd59, 7'd59), 2);
    run_case("R8 bcd12 11 to 12", 1'b1, 1'b1, tm(1'b1, 6'h11, 7'h59, 7'h59), 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule